// File: doc/BRIEF.md
# Debug Scan Port Controller

This block is the serial scan front end of an on-chip debugger. It walks the standard sixteen-state test access port graph on the rising edges of the test clock, keeps a five-bit instruction, and routes the serial data path to one of three data registers: a fixed 32-bit identification word, a 32-bit transport control/status word, and a debug-bus access register whose length is the debug address width plus 34 bits.

A companion request handler connects to the other side. It presents the value the access register should capture, and it receives the shifted word together with a one-cycle update strobe. A write to bit 16 of the control word raises a separate reset strobe, which the handler uses to clear its own state. Bits leave on the serial output least significant first. A register with no matching instruction keeps its previous contents and length.

Top module: `jtag_dbg_tap`

## Requirements
- R1: The controller advances one state per `tck` rising edge, following the standard test access port graph on the sampled `tms`. Five consecutive edges with `tms`=1 reach Test-Logic-Reset from any state. Select-IR-Scan with `tms`=1 also goes to Test-Logic-Reset.
- R2: Asynchronous reset (`trst_n` low) and every entry into Test-Logic-Reset make instruction 5'h01 the active instruction.
- R3: The instruction register is 5 bits wide. Capture-IR loads 5'b00001, and a shifted instruction takes effect only at Update-IR.
- R4: On entering Shift-DR or Shift-IR, `tdo` shows bit 0 of the selected register. Outside the shift states `tdo` holds its value. Data leaves least significant bit first.
- R5: In a shift state the selected register shifts right once per edge. The sampled `tdi` enters at the top bit of the register's current length.
- R6: Instruction 5'h01 captures the 32-bit `IDCODE` parameter.
- R7: Instruction 5'h10 captures a 32-bit control word with the following fields: [3:0]=1, [9:4]=`ABITS`, [11:10]=`dmi_status`, [14:12]=`idle_hint`, all other bits 0.
- R8: Instruction 5'h11 captures `dmi_capture` into a register `ABITS`+34 bits long.
- R9: Capture-DR under any other instruction leaves the data register's contents and length unchanged.
- R10: In Update-DR under instruction 5'h11, `dmi_update` is high for exactly one `tck` cycle and `dmi_shift` carries the shifted word. Under any other instruction `dmi_update` stays low.
- R11: In Update-DR under instruction 5'h10, `dmi_reset` is high if bit 16 of the shifted word is 1, and low otherwise.
- R12: Leaving Shift-DR through Exit1, Pause and Exit2 and then returning to Shift-DR continues the scan without losing or repeating bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled at each rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, registered |
| dmi_status | input | 2 | Status field reported in the control word |
| idle_hint | input | 3 | Idle-cycle hint reported in the control word |
| dmi_capture | input | ABITS+34 | Value captured by the debug-bus access register |
| dmi_shift | output | ABITS+34 | Current data register contents (shifted word at update) |
| dmi_update | output | 1 | Update strobe for the debug-bus access register |
| dmi_reset | output | 1 | Control-word reset request |

## Verification
Two functions meet on the same edge: the last shift into a register and the departure from Shift-DR into Exit1. The same happens with a pause, which leaves Shift-DR on one bit and re-enters it later. The bench scans a register with a pause in the middle and compares the full word on `tdo` against the captured value, so a bit that is dropped or repeated at either boundary shows up. It also fills a register and then reads it back under an unknown instruction. That read-back shows that the last `tdi` bit landed at the top of the correct length on the edge that left the shift state.

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap #(
  parameter int          ABITS  = 7,
  parameter logic [31:0] IDCODE = 32'h1BEE_F0A3
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [1:0]        dmi_status,
  input  logic [2:0]        idle_hint,
  input  logic [ABITS+33:0] dmi_capture,
  output logic [ABITS+33:0] dmi_shift,
  output logic              dmi_update,
  output logic              dmi_reset
);
  localparam int DLEN = ABITS + 34;
  localparam logic [4:0] IR_IDC  = 5'h01;
  localparam logic [4:0] IR_CTRL = 5'h10;
  localparam logic [4:0] IR_DMI  = 5'h11;
  localparam logic [4:0] IR_CAPT = 5'b00001;

  typedef enum logic [3:0] {
    TLR    = 4'd0,  RTI    = 4'd1,  SEL_DR = 4'd2,  CAP_DR = 4'd3,
    SH_DR  = 4'd4,  E1_DR  = 4'd5,  P_DR   = 4'd6,  E2_DR  = 4'd7,
    UPD_DR = 4'd8,  SEL_IR = 4'd9,  CAP_IR = 4'd10, SH_IR  = 4'd11,
    E1_IR  = 4'd12, P_IR   = 4'd13, E2_IR  = 4'd14, UPD_IR = 4'd15
  } tap_st_e;

  tap_st_e st, nxt;
  logic [4:0]      ir, irsh, irsh_n;
  logic [DLEN-1:0] dr, dr_n;
  logic            len32, len32_n;
  logic            tdo_q;
  logic [31:0]     ctrl_word;

  assign ctrl_word = {15'd0, 1'b0, 1'b0, idle_hint, dmi_status, 6'(ABITS), 4'd1};

  always_comb begin
    unique case (st)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? E1_DR  : SH_DR;
      SH_DR:   nxt = tms ? E1_DR  : SH_DR;
      E1_DR:   nxt = tms ? UPD_DR : P_DR;
      P_DR:    nxt = tms ? E2_DR  : P_DR;
      E2_DR:   nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? E1_IR  : SH_IR;
      SH_IR:   nxt = tms ? E1_IR  : SH_IR;
      E1_IR:   nxt = tms ? UPD_IR : P_IR;
      P_IR:    nxt = tms ? E2_IR  : P_IR;
      E2_IR:   nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  always_comb begin
    dr_n    = dr;
    len32_n = len32;
    if (st == SH_DR) begin
      dr_n = dr >> 1;
      if (len32) dr_n[31] = tdi;
      else       dr_n[DLEN-1] = tdi;
    end
    if (nxt == CAP_DR) begin
      case (ir)
        IR_IDC:  begin dr_n = DLEN'(IDCODE);    len32_n = 1'b1; end
        IR_CTRL: begin dr_n = DLEN'(ctrl_word); len32_n = 1'b1; end
        IR_DMI:  begin dr_n = dmi_capture;      len32_n = 1'b0; end
        default: ;
      endcase
    end
  end

  always_comb begin
    irsh_n = irsh;
    if (st == SH_IR)   irsh_n = {tdi, irsh[4:1]};
    if (nxt == CAP_IR) irsh_n = IR_CAPT;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st    <= TLR;
      ir    <= IR_IDC;
      irsh  <= IR_CAPT;
      dr    <= '0;
      len32 <= 1'b1;
      tdo_q <= 1'b0;
    end else begin
      st    <= nxt;
      dr    <= dr_n;
      len32 <= len32_n;
      irsh  <= irsh_n;
      if (nxt == SH_DR)      tdo_q <= dr_n[0];
      else if (nxt == SH_IR) tdo_q <= irsh_n[0];
      if (nxt == TLR)         ir <= IR_IDC;
      else if (nxt == UPD_IR) ir <= irsh;
    end
  end

  assign tdo        = tdo_q;
  assign dmi_shift  = dr;
  assign dmi_update = (st == UPD_DR) && (ir == IR_DMI);
  assign dmi_reset  = (st == UPD_DR) && (ir == IR_CTRL) && dr[16];
endmodule

// File: rtl/jtag_dbg_tap_chk.sv
module jtag_dbg_tap_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] st,
  input logic [4:0] ir,
  input logic       tdo,
  input logic       dmi_update
);
  logic [2:0] ncyc;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ncyc <= '0;
    else if (ncyc != 5) ncyc <= ncyc + 3'd1;
  end

  AST_FIVE_ONES_TLR: assert property (@(posedge tck) disable iff (!trst_n)
    (ncyc == 3'd5 && tms && $past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4))
      |=> (st == 4'd0)); // R1

  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    (st == 4'd0) |-> (ir == 5'h01)); // R2

  AST_TDO_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (ncyc != 3'd0 && st != 4'd4 && st != 4'd11) |-> $stable(tdo)); // R4

  AST_UPD_FROM_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
    (ncyc != 3'd0 && dmi_update) |-> ($past(st) == 4'd5 || $past(st) == 4'd7)); // R10

  AST_UPD_PULSE: assert property (@(posedge tck) disable iff (!trst_n)
    dmi_update |=> !dmi_update); // R10
endmodule

bind jtag_dbg_tap jtag_dbg_tap_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir(ir),
  .tdo(tdo), .dmi_update(dmi_update)
);

// File: tb/jtag_dbg_tap_tb_top.sv
module jtag_dbg_tap_tb_top;
  localparam int          ABITS = 7;
  localparam int          DLEN  = ABITS + 34;
  localparam logic [31:0] IDC   = 32'h1BEE_F0A3;
  localparam logic [63:0] RSP   = 64'h0AB_CDEF_0123;
  localparam logic [63:0] CTRLW = 64'h5871;
  localparam logic [63:0] PATA  = 64'hC3A5_96E1;
  localparam logic [63:0] PATP  = 64'h155_3C0F_F00D;
  localparam int NV = 5;
  localparam logic [4:0]  V_IR  [NV] = '{5'h01, 5'h07, 5'h10, 5'h11, 5'h1F};
  localparam int          V_LEN [NV] = '{32, 32, 32, DLEN, DLEN};
  localparam logic [63:0] V_IN  [NV] = '{PATA, 64'h0, 64'h0, PATP, 64'h0};
  localparam logic [63:0] V_EXP [NV] = '{64'(IDC), PATA, CTRLW, RSP, PATP};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, dmi_update, dmi_reset;
  logic [DLEN-1:0] dmi_shift;
  logic s_upd, s_rst;
  logic [63:0] s_req;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  jtag_dbg_tap #(.ABITS(ABITS), .IDCODE(IDC)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .dmi_status(2'b10), .idle_hint(3'b101), .dmi_capture(RSP[DLEN-1:0]),
    .dmi_shift(dmi_shift), .dmi_update(dmi_update), .dmi_reset(dmi_reset)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic so);
    @(negedge tck);
    so = tdo; s_upd = dmi_update; s_rst = dmi_reset; s_req = 64'(dmi_shift);
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic scan_ir(input logic [4:0] ins, output logic [4:0] cap);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 5; i++) step(i == 4, ins[i], cap[i]);
    step(1, 0, x); step(0, 0, x);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                         output logic [63:0] dout, output logic upd, output logic rst,
                         output logic [63:0] req);
    logic x;
    dout = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      step((i == n-1) || (i == pause_at), din[i], dout[i]);
      if (i == pause_at && i != n-1) begin
        step(0, 0, x); step(0, 0, x); step(1, 0, x); step(0, 0, x);
      end
    end
    step(1, 0, x); step(0, 0, x);
    upd = s_upd; rst = s_rst; req = s_req;
  endtask

  initial begin
    logic [4:0] c;
    logic [63:0] o, q;
    logic u, r, x;
    #12;
    chk("R2 reset tdo", 64'(tdo), 0);
    chk("R10 reset update", 64'(dmi_update), 0);
    chk("R11 reset rst", 64'(dmi_reset), 0);
    @(negedge tck); trst_n = 1'b1;
    step(0, 0, x);

    for (int v = 0; v < NV; v++) begin
      scan_ir(V_IR[v], c);
      chk("R3 ir capture", 64'(c), 64'h01);
      scan_dr(V_LEN[v], V_IN[v], -1, o, u, r, q);
      chk("R6/R7/R8/R9/R5 capture", o, V_EXP[v]);
      chk("R10 strobe", 64'(u), 64'(V_IR[v] == 5'h11));
      if (V_IR[v] == 5'h11) chk("R10 shifted word", q, PATP);
    end

    scan_ir(5'h10, c);
    scan_dr(32, 64'h1_0000, -1, o, u, r, q);
    chk("R11 reset bit set", 64'(r), 1);
    scan_dr(32, 64'h0, -1, o, u, r, q);
    chk("R11 reset bit clear", 64'(r), 0);

    step(1, 0, x); step(1, 0, x); step(1, 0, x); step(0, 0, x);
    scan_dr(32, 64'h0, -1, o, u, r, q);
    chk("R1 sel-ir exit to reset", o, 64'(IDC));

    scan_ir(5'h10, c);
    step(1, 0, x); step(0, 0, x); step(0, 0, x); step(0, 0, x); step(0, 0, x);
    for (int k = 0; k < 5; k++) step(1, 0, x);
    step(0, 0, x);
    scan_dr(32, 64'h0, -1, o, u, r, q);
    chk("R1 five ones reset", o, 64'(IDC));

    scan_dr(32, 64'h0, 10, o, u, r, q);
    chk("R12 pause resume", o, 64'(IDC));

    @(negedge tck); q = 64'(tdo);
    step(0, 0, x); step(0, 0, x); step(0, 0, x);
    @(negedge tck);
    chk("R4 tdo held in idle", 64'(tdo), q);

    scan_ir(5'h11, c);
    @(negedge tck); trst_n = 1'b0;
    @(negedge tck); trst_n = 1'b1;
    step(0, 0, x);
    scan_dr(32, 64'h0, -1, o, u, r, q);
    chk("R2 async reset instr", o, 64'(IDC));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule